// File: doc/BRIEF.md
# Pipelined Multiply-Accumulate Unit

This block is a multiply-accumulate engine placed next to a processor core. On each issue cycle the core hands it two operands, an opcode, an operand size and a number format. The engine multiplies the operands. It then either loads the product into its single 32-bit accumulator or adds it to, or subtracts it from, the accumulator. The arithmetic runs through a fixed three-register pipeline: operand capture, product, accumulate. A new 16-bit operation can enter on every cycle.

The 16x16 multiply is the fast path. It accepts unsigned integer, signed integer and signed fractional (Q15 by Q15 into Q31) operands. A 32-bit operand multiply makes two passes through the multiplier array and keeps only the low 32 bits of the product. It therefore holds off the issue handshake for one cycle.

The accumulator saturates or wraps on overflow, as chosen per operation. A sticky flag records any overflow. A direct load port writes the accumulator and clears the flag.

Top module: `mac_engine`

## Requirements
- R1: An accepted 16-bit operation (issue_valid and issue_ready high at a rising edge) raises res_valid for exactly one cycle, and updates acc_out, three cycles after the issue cycle. res_valid is low in every cycle where no operation retires.
- R2: 16-bit operations can be issued on consecutive cycles without any stall. Each one accumulates onto the result of the operation before it.
- R3: op_fmt selects the format of a 16-bit operation, using the low 16 bits of opa and opb. The codes are: 0 unsigned integer (zero-extended), 1 signed integer, 2 signed fractional, 3 treated as signed integer.
- R4: In fractional format the product is doubled (Q31). The single case 0x8000 times 0x8000 yields 0x7FFFFFFF and sets ovf_flag.
- R5: op_code selects the accumulator update. The codes are: 0 load the product, 1 add the product, 2 subtract the product, 3 same as 0.
- R6: With op_wide=1 the full 32-bit operands are multiplied and only the low 32 bits of the product are kept; op_fmt is ignored. issue_ready is low in the cycle after such an operation is accepted, and the result retires four cycles after the issue cycle.
- R7: The accumulator holds a signed 32-bit value. The product enters the update as a signed value, zero-extended for 16-bit unsigned format and sign-extended otherwise. If the exact result leaves the signed 32-bit range, sat_mode (captured at issue) picks between clamping to 0x7FFFFFFF / 0x80000000 (1) and keeping the low 32 bits (0).
- R8: ovf_flag is set by any accumulate overflow or fractional saturation, and stays set until the accumulator is loaded through the load port.
- R9: acc_wr_en high at a rising edge writes acc_wr_data into the accumulator and clears ovf_flag.
- R10: When a load and a retiring operation meet at the same edge, the operation uses the loaded value as its base. ovf_flag then reflects only that operation.
- R11: During reset, acc_out is 0, ovf_flag is 0, res_valid is 0 and issue_ready is 1.
- R12: issue_valid is ignored while issue_ready is low: no result and no accumulator change follow from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Operation offered this cycle |
| issue_ready | output | 1 | Engine can accept an operation |
| op_wide | input | 1 | 1 = 32-bit operands, 0 = 16-bit |
| op_fmt | input | 2 | Number format of 16-bit operands |
| op_code | input | 2 | Accumulator update kind |
| sat_mode | input | 1 | 1 = saturate on overflow, 0 = wrap |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| acc_wr_en | input | 1 | Direct accumulator write |
| acc_wr_data | input | 32 | Value for the direct write |
| acc_out | output | 32 | Accumulator value |
| ovf_flag | output | 1 | Sticky overflow flag |
| res_valid | output | 1 | An operation retired this cycle |

## Verification
The hardest situation to reach from the ports is a direct accumulator load landing on the same edge as an operation leaving the last stage. The bench issues an operation, waits exactly two cycles and then asserts the load port, so that both meet at one edge. It then checks that the result is built on the loaded value. Overflow and saturation paths are reached by sweeping boundary operands (0x7FFF, 0x8000, 0xFFFF) back to back with alternating saturation mode, so that chained sums cross the signed limits. Wide operations are mixed with narrow ones to exercise the stall and the in-order retirement.

// File: rtl/mac_pkg.sv
package mac_pkg;

    typedef enum logic [1:0] {
        FMT_UNS  = 2'd0,
        FMT_SGN  = 2'd1,
        FMT_FRAC = 2'd2,
        FMT_RSV  = 2'd3
    } mac_fmt_e;

    typedef enum logic [1:0] {
        OPC_LOAD = 2'd0,
        OPC_ADD  = 2'd1,
        OPC_SUB  = 2'd2,
        OPC_RSV  = 2'd3
    } mac_opc_e;

endpackage

// File: rtl/mac_mul_array.sv
// Signed (HALF_W+1) x (HALF_W+1) multiplier array. Each operand is
// extended by one bit, as a sign or as zero, so that one array serves
// the signed and the unsigned formats.
module mac_mul_array #(
    parameter int HALF_W = 16,
    localparam int PW    = 2 * HALF_W + 1
) (
    input  logic [HALF_W-1:0] a,
    input  logic [HALF_W-1:0] b,
    input  logic              a_sgn,
    input  logic              b_sgn,
    output logic [PW-1:0]     p
);
    logic signed [HALF_W:0] ax;
    logic signed [HALF_W:0] bx;
    logic signed [PW-1:0]   prod;

    always_comb begin
        ax   = {a_sgn & a[HALF_W-1], a};
        bx   = {b_sgn & b[HALF_W-1], b};
        prod = ax * bx;
        p    = prod;
    end
endmodule

// File: rtl/mac_mul_stage.sv
// Pipeline stages one and two: operand capture, then product.
// A wide operation stays in stage one for two passes.
module mac_mul_stage
    import mac_pkg::*;
#(
    parameter int HALF_W = 16,
    localparam int W     = 2 * HALF_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_fire,
    input  logic         in_wide,
    input  logic [1:0]   in_fmt,
    input  logic [1:0]   in_opc,
    input  logic         in_sat,
    input  logic [W-1:0] in_a,
    input  logic [W-1:0] in_b,
    output logic         busy,
    output logic         out_valid,
    output mac_opc_e     out_opc,
    output logic         out_sat,
    output logic         out_fsat,
    output logic [W:0]   out_prod
);
    typedef struct packed {
        logic         v;
        logic         wide;
        mac_fmt_e     fmt;
        mac_opc_e     opc;
        logic         sat;
        logic         pass;
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic [W-1:0] part;
    } s1_t;

    typedef struct packed {
        logic     v;
        mac_opc_e opc;
        logic     sat;
        logic     fsat;
        logic [W:0] prod;
    } s2_t;

    typedef struct packed {
        s1_t s1;
        s2_t s2;
    } st_t;

    st_t st_d, st_q;

    logic [HALF_W-1:0] arr_a, arr_b;
    logic              arr_as, arr_bs;
    logic [W:0]        arr_p;
    logic [HALF_W-1:0] cross_lo;
    logic [HALF_W-1:0] cross_sum;
    logic [W-1:0]      wide_lo;
    logic              frac_min;
    logic [W:0]        nar_prod;
    logic              nar_fsat;

    // Array operand selection: pass 1 of a wide op uses the upper half of a.
    always_comb begin
        arr_a  = st_q.s1.a[HALF_W-1:0];
        arr_b  = st_q.s1.b[HALF_W-1:0];
        arr_as = (st_q.s1.fmt != FMT_UNS) && !st_q.s1.wide;
        arr_bs = (st_q.s1.fmt != FMT_UNS) && !st_q.s1.wide;
        if (st_q.s1.wide && st_q.s1.pass) begin
            arr_a = st_q.s1.a[W-1:HALF_W];
        end
    end

    mac_mul_array #(.HALF_W(HALF_W)) u_array (
        .a     (arr_a),
        .b     (arr_b),
        .a_sgn (arr_as),
        .b_sgn (arr_bs),
        .p     (arr_p)
    );

    // Only the low half of the second cross term reaches the low 32 bits.
    assign cross_lo = st_q.s1.a[HALF_W-1:0] * st_q.s1.b[W-1:HALF_W];

    always_comb begin
        st_d      = st_q;
        st_d.s2.v = 1'b0;

        frac_min  = (st_q.s1.a[HALF_W-1:0] == {1'b1, {(HALF_W-1){1'b0}}}) &&
                    (st_q.s1.b[HALF_W-1:0] == {1'b1, {(HALF_W-1){1'b0}}});

        nar_fsat  = 1'b0;
        if (st_q.s1.fmt == FMT_FRAC) begin
            if (frac_min) begin
                nar_prod = {2'b00, {(W-1){1'b1}}};
                nar_fsat = 1'b1;
            end else begin
                nar_prod = {arr_p[W-1:0], 1'b0};
            end
        end else begin
            nar_prod = arr_p;
        end

        cross_sum = arr_p[HALF_W-1:0] + cross_lo;
        wide_lo   = st_q.s1.part + {cross_sum, {HALF_W{1'b0}}};

        if (st_q.s1.v) begin
            if (st_q.s1.wide && !st_q.s1.pass) begin
                st_d.s1.pass = 1'b1;
                st_d.s1.part = arr_p[W-1:0];
            end else begin
                st_d.s2.v   = 1'b1;
                st_d.s2.opc = st_q.s1.opc;
                st_d.s2.sat = st_q.s1.sat;
                if (st_q.s1.wide) begin
                    st_d.s2.prod = {wide_lo[W-1], wide_lo};
                    st_d.s2.fsat = 1'b0;
                end else begin
                    st_d.s2.prod = nar_prod;
                    st_d.s2.fsat = nar_fsat;
                end
                st_d.s1.v = 1'b0;
            end
        end

        if (in_fire) begin
            st_d.s1.v    = 1'b1;
            st_d.s1.wide = in_wide;
            st_d.s1.fmt  = mac_fmt_e'(in_fmt);
            st_d.s1.opc  = mac_opc_e'(in_opc);
            st_d.s1.sat  = in_sat;
            st_d.s1.pass = 1'b0;
            st_d.s1.a    = in_a;
            st_d.s1.b    = in_b;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy      = st_q.s1.v && st_q.s1.wide && !st_q.s1.pass;
    assign out_valid = st_q.s2.v;
    assign out_opc   = st_q.s2.opc;
    assign out_sat   = st_q.s2.sat;
    assign out_fsat  = st_q.s2.fsat;
    assign out_prod  = st_q.s2.prod;

    // R6: the stall for a wide op lasts a single cycle
    p_busy_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);

    // R12: nothing is accepted while the array is on its first wide pass
    p_no_fire_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !in_fire);
endmodule

// File: rtl/mac_acc_stage.sv
// Pipeline stage three: accumulator update, overflow, load port.
module mac_acc_stage
    import mac_pkg::*;
#(
    parameter int ACC_W = 32,
    localparam int XW   = ACC_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  mac_opc_e         in_opc,
    input  logic             in_sat,
    input  logic             in_fsat,
    input  logic [ACC_W:0]   in_prod,
    input  logic             ld_en,
    input  logic [ACC_W-1:0] ld_data,
    output logic [ACC_W-1:0] acc,
    output logic             ovf,
    output logic             res_valid
);
    localparam logic [ACC_W-1:0] MAXV = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic [ACC_W-1:0] MINV = {1'b1, {(ACC_W-1){1'b0}}};

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             ovf;
        logic             rv;
    } st_t;

    st_t st_d, st_q;

    logic [ACC_W-1:0] base;
    logic             ovf_base;
    logic [XW-1:0]    base_x;
    logic [XW-1:0]    prod_x;
    logic [XW-1:0]    sum;
    logic             ovf_now;
    logic [ACC_W-1:0] result;

    always_comb begin
        // a coincident load is ordered ahead of the retiring operation
        base     = ld_en ? ld_data : st_q.acc;
        ovf_base = ld_en ? 1'b0 : st_q.ovf;
        base_x   = {{2{base[ACC_W-1]}}, base};
        prod_x   = {in_prod[ACC_W], in_prod};

        case (in_opc)
            OPC_ADD: sum = base_x + prod_x;
            OPC_SUB: sum = base_x - prod_x;
            default: sum = prod_x;
        endcase

        ovf_now = !((sum[XW-1:ACC_W-1] == '0) || (sum[XW-1:ACC_W-1] == '1));

        if (ovf_now && in_sat) begin
            result = sum[XW-1] ? MINV : MAXV;
        end else begin
            result = sum[ACC_W-1:0];
        end

        st_d    = st_q;
        st_d.rv = 1'b0;
        if (in_valid) begin
            st_d.acc = result;
            st_d.ovf = ovf_base | ovf_now | in_fsat;
            st_d.rv  = 1'b1;
        end else if (ld_en) begin
            st_d.acc = ld_data;
            st_d.ovf = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc       = st_q.acc;
    assign ovf       = st_q.ovf;
    assign res_valid = st_q.rv;

    // R8: the flag only falls through the load port
    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ovf && !ld_en) |=> st_q.ovf);

    // R9: a load with no retiring op lands unchanged and clears the flag
    p_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_en && !in_valid) |=> (st_q.acc == $past(ld_data)) && !st_q.ovf);

    // R7: a saturating op that overflows leaves a limit value
    p_clamp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sat && ovf_now) |=>
            ((st_q.acc == MAXV) || (st_q.acc == MINV)) && st_q.ovf);

    // R1: the accumulator only moves on a retire or a load
    p_acc_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !ld_en) |=> $stable(st_q.acc) && !st_q.rv);
endmodule

// File: rtl/mac_engine.sv
module mac_engine
    import mac_pkg::*;
#(
    parameter int HALF_W = 16,
    localparam int ACC_W = 2 * HALF_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue_valid,
    output logic             issue_ready,
    input  logic             op_wide,
    input  logic [1:0]       op_fmt,
    input  logic [1:0]       op_code,
    input  logic             sat_mode,
    input  logic [ACC_W-1:0] opa,
    input  logic [ACC_W-1:0] opb,
    input  logic             acc_wr_en,
    input  logic [ACC_W-1:0] acc_wr_data,
    output logic [ACC_W-1:0] acc_out,
    output logic             ovf_flag,
    output logic             res_valid
);
    logic             fire;
    logic             busy;
    logic             m_valid;
    mac_opc_e         m_opc;
    logic             m_sat;
    logic             m_fsat;
    logic [ACC_W:0]   m_prod;

    assign issue_ready = !busy;
    assign fire        = issue_valid && issue_ready;

    mac_mul_stage #(.HALF_W(HALF_W)) u_mul (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_fire   (fire),
        .in_wide   (op_wide),
        .in_fmt    (op_fmt),
        .in_opc    (op_code),
        .in_sat    (sat_mode),
        .in_a      (opa),
        .in_b      (opb),
        .busy      (busy),
        .out_valid (m_valid),
        .out_opc   (m_opc),
        .out_sat   (m_sat),
        .out_fsat  (m_fsat),
        .out_prod  (m_prod)
    );

    mac_acc_stage #(.ACC_W(ACC_W)) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (m_valid),
        .in_opc    (m_opc),
        .in_sat    (m_sat),
        .in_fsat   (m_fsat),
        .in_prod   (m_prod),
        .ld_en     (acc_wr_en),
        .ld_data   (acc_wr_data),
        .acc       (acc_out),
        .ovf       (ovf_flag),
        .res_valid (res_valid)
    );

    // R1: narrow issue retires three cycles later
    p_lat_narrow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !op_wide) |-> ##3 res_valid);

    // R6: wide issue retires four cycles later
    p_lat_wide_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && op_wide) |-> ##4 res_valid);

    // R6: the handshake drops right after a wide acceptance
    p_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && op_wide) |=> !issue_ready);

    // R4: the fractional -1 x -1 case raises the flag when it retires
    p_frac_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !op_wide && (op_fmt == 2'd2) &&
         (opa[HALF_W-1:0] == {1'b1, {(HALF_W-1){1'b0}}}) &&
         (opb[HALF_W-1:0] == {1'b1, {(HALF_W-1){1'b0}}})) |-> ##3 ovf_flag);
endmodule

// File: tb/mac_engine_tb.sv
module mac_engine_tb;
    localparam int CLK_PERIOD = 10;
    localparam longint MAXV = 64'sd2147483647;
    localparam longint MINV = -64'sd2147483648;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        issue_valid;
    logic        issue_ready;
    logic        op_wide;
    logic [1:0]  op_fmt;
    logic [1:0]  op_code;
    logic        sat_mode;
    logic [31:0] opa, opb;
    logic        acc_wr_en;
    logic [31:0] acc_wr_data;
    logic [31:0] acc_out;
    logic        ovf_flag;
    logic        res_valid;

    mac_engine u_dut (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_ready(issue_ready),
        .op_wide(op_wide), .op_fmt(op_fmt), .op_code(op_code), .sat_mode(sat_mode),
        .opa(opa), .opb(opb), .acc_wr_en(acc_wr_en), .acc_wr_data(acc_wr_data),
        .acc_out(acc_out), .ovf_flag(ovf_flag), .res_valid(res_valid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int errs = 0;
    int checks = 0;

    bit          due_v   [64];
    logic [31:0] due_acc [64];
    bit          due_ovf [64];
    string       due_tag [64];

    logic [31:0] m_acc = '0;
    bit          m_ovf = 1'b0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        int idx;
        @(negedge clk);
        idx = cyc % 64;
        if (due_v[idx]) begin
            chk(res_valid === 1'b1, {due_tag[idx], " res_valid"}, longint'(res_valid), 1);
            chk(acc_out === due_acc[idx], {due_tag[idx], " acc"}, longint'(acc_out), longint'(due_acc[idx]));
            chk(ovf_flag === due_ovf[idx], {due_tag[idx], " ovf"}, longint'(ovf_flag), longint'(due_ovf[idx]));
            due_v[idx] = 1'b0;
        end else begin
            chk(res_valid === 1'b0, "R1 no retire expected", longint'(res_valid), 0);
        end
    endtask

    function automatic longint m_prod(input logic [31:0] a, input logic [31:0] b,
                                      input logic [1:0] fmt, input bit wide, output bit fsat);
        longint ax, bx, p;
        logic [31:0] lo;
        fsat = 1'b0;
        if (wide) begin
            lo = a * b;
            return longint'($signed(lo));
        end
        ax = (fmt == 2'd0) ? longint'(a[15:0]) : longint'($signed(a[15:0]));
        bx = (fmt == 2'd0) ? longint'(b[15:0]) : longint'($signed(b[15:0]));
        p  = ax * bx;
        if (fmt == 2'd2) begin
            if (a[15:0] == 16'h8000 && b[15:0] == 16'h8000) begin
                fsat = 1'b1;
                return MAXV;
            end
            p = p * 2;
        end
        return p;
    endfunction

    task automatic do_issue(input logic [31:0] a, input logic [31:0] b, input logic [1:0] fmt,
                            input logic [1:0] opc, input bit wide, input bit sat, input string tag);
        longint p, s;
        bit fs, ov;
        int idx;
        while (issue_ready !== 1'b1) step();
        issue_valid = 1'b1; opa = a; opb = b; op_fmt = fmt; op_code = opc;
        op_wide = wide; sat_mode = sat;
        p = m_prod(a, b, fmt, wide, fs);
        if (opc == 2'd1)      s = longint'($signed(m_acc)) + p;
        else if (opc == 2'd2) s = longint'($signed(m_acc)) - p;
        else                  s = p;
        ov = (s > MAXV) || (s < MINV);
        if (ov && sat) m_acc = (s > MAXV) ? 32'h7FFFFFFF : 32'h80000000;
        else           m_acc = s[31:0];
        m_ovf = m_ovf | ov | fs;
        idx = (cyc + 3 + (wide ? 1 : 0)) % 64;
        due_v[idx] = 1'b1; due_acc[idx] = m_acc; due_ovf[idx] = m_ovf; due_tag[idx] = tag;
        step();
        issue_valid = 1'b0;
    endtask

    task automatic do_load(input logic [31:0] d);
        acc_wr_en = 1'b1; acc_wr_data = d;
        step();
        acc_wr_en = 1'b0;
        m_acc = d; m_ovf = 1'b0;
        chk(acc_out === d, "R9 load value", longint'(acc_out), longint'(d));
        chk(ovf_flag === 1'b0, "R9 load clears flag", longint'(ovf_flag), 0);
    endtask

    task automatic drain();
        repeat (6) step();
    endtask

    function automatic logic [31:0] nval(input int i);
        case (i)
            0: return 32'h0000_0000;
            1: return 32'h0000_0001;
            2: return 32'h0000_7FFF;
            3: return 32'h0000_8000;
            4: return 32'hABCD_FFFF;
            5: return 32'h0000_1234;
            default: return 32'h5555_C000;
        endcase
    endfunction

    function automatic logic [31:0] wval(input int i);
        case (i)
            0: return 32'h0000_0000;
            1: return 32'h0000_0001;
            2: return 32'hFFFF_FFFF;
            3: return 32'h8000_0000;
            default: return 32'h1234_5678;
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        errs++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; issue_valid = 1'b0; op_wide = 1'b0; op_fmt = 2'd0; op_code = 2'd0;
        sat_mode = 1'b0; opa = '0; opb = '0; acc_wr_en = 1'b0; acc_wr_data = '0;
        repeat (3) step();
        // R11 reset state
        chk(acc_out === 32'h0, "R11 acc", longint'(acc_out), 0);
        chk(ovf_flag === 1'b0, "R11 ovf", longint'(ovf_flag), 0);
        chk(res_valid === 1'b0, "R11 res_valid", longint'(res_valid), 0);
        chk(issue_ready === 1'b1, "R11 issue_ready", longint'(issue_ready), 1);
        rst_n = 1'b1;
        step();

        // R2 R3 R5: back-to-back sweep of 16-bit formats and opcodes
        for (int f = 0; f < 4; f++) begin
            do_load(32'h0);
            for (int i = 0; i < 7; i++) begin
                for (int j = 0; j < 7; j++) begin
                    do_issue(nval(i), nval(j), 2'(f), 2'((i * 7 + j) % 4), 1'b0,
                             1'((i + j) % 2), "R2/R3/R5 sweep");
                end
            end
            drain();
        end

        // R4: fractional -1 x -1 saturation
        do_load(32'h0);
        do_issue(32'h8000, 32'h8000, 2'd2, 2'd0, 1'b0, 1'b0, "R4 frac saturate");
        drain();
        chk(acc_out === 32'h7FFFFFFF, "R4 frac acc", longint'(acc_out), 64'h7FFFFFFF);
        chk(ovf_flag === 1'b1, "R4 frac flag", longint'(ovf_flag), 1);
        // R8: flag survives non-overflowing ops
        do_issue(32'h0, 32'h5, 2'd1, 2'd0, 1'b0, 1'b0, "R8 sticky");
        drain();
        chk(ovf_flag === 1'b1, "R8 flag sticky", longint'(ovf_flag), 1);

        // R7: clamp versus wrap at the positive limit
        do_load(32'h7FFFFFF0);
        do_issue(32'h0100, 32'h0100, 2'd1, 2'd1, 1'b0, 1'b1, "R7 clamp");
        drain();
        chk(acc_out === 32'h7FFFFFFF, "R7 clamp value", longint'(acc_out), 64'h7FFFFFFF);
        do_load(32'h7FFFFFF0);
        do_issue(32'h0100, 32'h0100, 2'd1, 2'd1, 1'b0, 1'b0, "R7 wrap");
        drain();
        chk(acc_out === 32'h8000FFF0, "R7 wrap value", longint'(acc_out), 64'h8000FFF0);
        do_load(32'h80000010);
        do_issue(32'h7FFF, 32'h7FFF, 2'd1, 2'd2, 1'b0, 1'b1, "R7 clamp negative");
        drain();
        chk(acc_out === 32'h80000000, "R7 negative limit", longint'(acc_out), 64'h80000000);

        // R6: wide sweep interleaved with narrow ops
        do_load(32'h0);
        for (int i = 0; i < 5; i++) begin
            for (int j = 0; j < 5; j++) begin
                do_issue(wval(i), wval(j), 2'(j % 4), 2'((i + j) % 3), 1'b1, 1'(i % 2), "R6 wide");
                chk(issue_ready === 1'b0, "R6 stall after wide", longint'(issue_ready), 0);
                do_issue(nval(i), nval(j), 2'd1, 2'd1, 1'b0, 1'(j % 2), "R6 narrow after wide");
            end
        end
        drain();

        // R12: issue during the stall cycle is ignored
        do_load(32'h00000100);
        do_issue(32'h10000, 32'h3, 2'd0, 2'd1, 1'b1, 1'b0, "R12 wide op");
        issue_valid = 1'b1; opa = 32'h7FFF; opb = 32'h7FFF; op_wide = 1'b0; op_code = 2'd0;
        chk(issue_ready === 1'b0, "R12 ready low", longint'(issue_ready), 0);
        step();
        issue_valid = 1'b0;
        drain();
        chk(acc_out === 32'h00030100, "R12 acc unaffected", longint'(acc_out), 64'h00030100);

        // R10: load meeting a retiring add at the same edge
        drain();
        m_acc = 32'h00001000; m_ovf = 1'b0;
        do_issue(32'h0002, 32'h0003, 2'd1, 2'd1, 1'b0, 1'b0, "R10 load plus retire");
        step();
        acc_wr_en = 1'b1; acc_wr_data = 32'h00001000;
        step();
        acc_wr_en = 1'b0;
        chk(acc_out === 32'h00001006, "R10 base is loaded value", longint'(acc_out), 64'h1006);
        drain();

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule